// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block is the register file and progress tracker of one bus-master DMA channel in a SCSI host adapter. Software programs a start count, a start address and a start descriptor address, then writes a command. A start command copies the three start values into working copies. From then on, the data path asks for permission to move each chunk, giving a direction and a length. The block grants at most the remaining working count and moves the working address forward by the granted amount. The actual memory cycles are done elsewhere.

The status register carries done, abort and error flags. A mode input chooses how software clears them. In one mode, software writes ones to the flags it wants cleared. In the other mode, status writes are ignored and a status read clears the flags. The SCSI core's interrupt line is merged into the status word whenever it is read. The core also has a command-complete pulse, which retires whatever count is left.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset, these registers read as follows: command 0, start count 0, start address 0, working count 0, status 0, start descriptor 0, working address 0xFFFFFFFF and working descriptor 0xFFFFFFFD. All registered outputs are low or zero.
- R2: Register indices are: 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor, 7 working descriptor. Indices 0, 1, 2 and 6 store the full 32-bit written value. Writes to 3, 4 and 7 have no effect. Reads are combinational, in the same cycle as `host_rd`.
- R3: A command write with bits [1:0] = 3 (start) loads working count from start count, working address from start address and working descriptor from start descriptor. It also clears status bits [5:0]. All of this is visible on the next cycle.
- R4: A command write with bits [1:0] = 2 (abort) raises `abort_req` for exactly one cycle, on the cycle after the write. A code of 0 (idle) or 1 (blast) only stores the command.
- R5: Status reads return bit 4 set while `core_irq` is high. Bit 3 is done, bit 2 is abort and bit 1 is error.
- R6: With `clr_by_write` high, a status write clears each of bits 1, 2 and 3 where the written data has a one. Status reads leave the flags unchanged.
- R7: With `clr_by_write` low, status writes are ignored. A status read returns the current flags, and after that read bits 1, 2 and 3 are clear.
- R8: A chunk request whose `xfer_to_mem` differs from command bit 7 pulses `xfer_rej` on the next cycle with a zero grant. The working count and working address do not change.
- R9: A matching chunk request pulses `xfer_ack` on the next cycle. The granted length is min(request length, working count). The address output is the working address before the update. The working count drops by the grant and the working address rises by it.
- R10: The done flag (status bit 3) is set when a granted chunk leaves the working count at zero.
- R11: A `core_done` pulse sets the working count to zero and sets the done flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| host_idx | input | 3 | Register index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational |
| clr_by_write | input | 1 | 1: write-one-to-clear flags; 0: clear-on-read |
| core_irq | input | 1 | Live SCSI core interrupt |
| core_done | input | 1 | Command-complete pulse from the SCSI core |
| xfer_req | input | 1 | Chunk request |
| xfer_to_mem | input | 1 | Chunk direction, 1 = device to memory |
| xfer_len | input | 32 | Requested chunk length |
| xfer_ack | output | 1 | Chunk granted (one cycle after request) |
| xfer_rej | output | 1 | Chunk rejected for direction |
| xfer_grant | output | 32 | Granted length |
| xfer_addr | output | 32 | Address for the granted chunk |
| abort_req | output | 1 | Abort pulse to the SCSI core |

## Verification
A working count that is off appears at two points. The first is the next granted length, one cycle after the request. The second is the point where done rises, which comes a chunk early or late. A wrong working address appears on `xfer_addr` at the next grant. A flag that clears under the wrong mode, or that misses a clear, shows on the very next status read. The bench therefore compares the registered outputs on every cycle and checks every read against a behavioural model. A divergence is caught within one chunk of its cause.

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan #(
  parameter int DW = 32,
  parameter int SW = 6,
  parameter logic [DW-1:0] WADDR_RST = 32'hFFFF_FFFF,
  parameter logic [DW-1:0] WDESC_RST = 32'hFFFF_FFFD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [2:0]    host_idx,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic          clr_by_write,
  input  logic          core_irq,
  input  logic          core_done,
  input  logic          xfer_req,
  input  logic          xfer_to_mem,
  input  logic [DW-1:0] xfer_len,
  output logic          xfer_ack,
  output logic          xfer_rej,
  output logic [DW-1:0] xfer_grant,
  output logic [DW-1:0] xfer_addr,
  output logic          abort_req
);
  localparam logic [2:0] I_CMD = 3'd0, I_SCNT = 3'd1, I_SADR = 3'd2, I_WCNT = 3'd3;
  localparam logic [2:0] I_WADR = 3'd4, I_STAT = 3'd5, I_SDSC = 3'd6, I_WDSC = 3'd7;
  localparam int B_DIR = 7;
  localparam int B_IRQ = 4;
  localparam int B_DONE = 3;
  localparam logic [SW-1:0] FLAG_MASK = SW'(6'b001110);

  logic [DW-1:0] cmd_q, scnt_q, sadr_q, wcnt_q, wadr_q, sdsc_q, wdsc_q;
  logic [SW-1:0] stat_q, stat_d;
  logic          ack_q, rej_q, abort_q;
  logic [DW-1:0] grant_q, addr_q;

  wire wr_cmd   = host_wr && host_idx == I_CMD;
  wire is_start = wr_cmd && host_wdata[1:0] == 2'd3;
  wire is_abort = wr_cmd && host_wdata[1:0] == 2'd2;
  wire dir_ok   = xfer_to_mem == cmd_q[B_DIR];
  wire take     = xfer_req && dir_ok;
  wire [DW-1:0] glen = (xfer_len < wcnt_q) ? xfer_len : wcnt_q;
  wire [DW-1:0] wcnt_left = wcnt_q - glen;
  wire stat_wr = host_wr && host_idx == I_STAT;
  wire stat_rd = host_rd && host_idx == I_STAT;

  logic [SW-1:0] stat_view;
  always_comb begin
    stat_view = stat_q;
    stat_view[B_IRQ] = stat_q[B_IRQ] | core_irq;
  end

  always_comb begin
    case (host_idx)
      I_CMD:   host_rdata = cmd_q;
      I_SCNT:  host_rdata = scnt_q;
      I_SADR:  host_rdata = sadr_q;
      I_WCNT:  host_rdata = wcnt_q;
      I_WADR:  host_rdata = wadr_q;
      I_STAT:  host_rdata = DW'(stat_view);
      I_SDSC:  host_rdata = sdsc_q;
      default: host_rdata = wdsc_q;
    endcase
  end

  always_comb begin
    stat_d = stat_q;
    if (stat_wr && clr_by_write) stat_d = stat_d & ~(host_wdata[SW-1:0] & FLAG_MASK);
    if (stat_rd && !clr_by_write) stat_d = stat_d & ~FLAG_MASK;
    if ((take && wcnt_left == '0) || core_done) stat_d[B_DONE] = 1'b1;
    if (is_start) stat_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      scnt_q <= '0;
      sadr_q <= '0;
      sdsc_q <= '0;
    end else if (host_wr) begin
      case (host_idx)
        I_CMD:  cmd_q  <= host_wdata;
        I_SCNT: scnt_q <= host_wdata;
        I_SADR: sadr_q <= host_wdata;
        I_SDSC: sdsc_q <= host_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      wadr_q <= WADDR_RST;
      wdsc_q <= WDESC_RST;
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (is_start) begin
        wcnt_q <= scnt_q;
        wadr_q <= sadr_q;
        wdsc_q <= sdsc_q;
      end else begin
        if (core_done) wcnt_q <= '0;
        else if (take) wcnt_q <= wcnt_left;
        if (take) wadr_q <= wadr_q + glen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rej_q   <= 1'b0;
      grant_q <= '0;
      addr_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      ack_q   <= take;
      rej_q   <= xfer_req && !dir_ok;
      grant_q <= take ? glen : '0;
      addr_q  <= take ? wadr_q : '0;
      abort_q <= is_abort;
    end
  end

  assign xfer_ack   = ack_q;
  assign xfer_rej   = rej_q;
  assign xfer_grant = grant_q;
  assign xfer_addr  = addr_q;
  assign abort_req  = abort_q;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    is_start |=> wcnt_q == $past(scnt_q) && wadr_q == $past(sadr_q) &&
                 wdsc_q == $past(sdsc_q) && stat_q == '0); // R3
  AST_ABORT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> cmd_q[1:0] == 2'd2); // R4
  AST_REJECT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_rej && !$past(core_done) && !$past(is_start) |->
      $stable(wcnt_q) && $stable(wadr_q) && xfer_grant == '0); // R8
  AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack && !$past(core_done) && !$past(is_start) |->
      wcnt_q == $past(wcnt_q) - xfer_grant && xfer_grant <= $past(wcnt_q)); // R9
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack && wcnt_q == '0 && !$past(is_start) |-> stat_q[B_DONE]); // R10
  AST_CORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    core_done && !is_start |=> wcnt_q == '0 && stat_q[B_DONE]); // R11
endmodule

// File: tb/scsi_dma_chan_bench.sv
module scsi_dma_chan_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, host_wr, host_rd, clr_by_write, core_irq, core_done, xfer_req, xfer_to_mem;
  logic [2:0] host_idx;
  logic [31:0] host_wdata, host_rdata, xfer_len, xfer_grant, xfer_addr;
  logic xfer_ack, xfer_rej, abort_req;

  scsi_dma_chan u_scsi_dma_chan (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .clr_by_write(clr_by_write),
    .core_irq(core_irq), .core_done(core_done), .xfer_req(xfer_req),
    .xfer_to_mem(xfer_to_mem), .xfer_len(xfer_len), .xfer_ack(xfer_ack),
    .xfer_rej(xfer_rej), .xfer_grant(xfer_grant), .xfer_addr(xfer_addr),
    .abort_req(abort_req));

  int total = 0, failed = 0;
  string tag = "R1";
  bit [31:0] m [8];
  bit e_ack, e_rej, e_abort;
  bit [31:0] e_grant, e_addr;

  task automatic check(input string what, input bit [31:0] act, input bit [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit [31:0] model_read(input int idx);
    bit [31:0] v = m[idx];
    if (idx == 5 && core_irq) v[4] = 1'b1;
    return v;
  endfunction

  task automatic model_step();
    int idx = int'(host_idx);
    bit [31:0] g;
    bit hit = xfer_req && (xfer_to_mem == m[0][7]);
    e_ack = hit;
    e_rej = xfer_req && !hit;
    e_grant = 0;
    e_addr = 0;
    e_abort = host_wr && idx == 0 && host_wdata[1:0] == 2;
    if (host_wr && idx == 5 && clr_by_write) m[5] &= ~(host_wdata & 32'hE);
    if (host_rd && idx == 5 && !clr_by_write) m[5] &= ~32'hE;
    if (hit) begin
      g = (xfer_len < m[3]) ? xfer_len : m[3];
      e_grant = g;
      e_addr = m[4];
      m[3] -= g;
      m[4] += g;
      if (m[3] == 0) m[5][3] = 1'b1;
    end
    if (core_done) begin m[3] = 0; m[5][3] = 1'b1; end
    if (host_wr && (idx == 0 || idx == 1 || idx == 2 || idx == 6)) m[idx] = host_wdata;
    if (host_wr && idx == 0 && host_wdata[1:0] == 3) begin
      m[3] = m[1]; m[4] = m[2]; m[7] = m[6]; m[5] = 0;
    end
  endtask

  task automatic tick();
    #1;
    if (host_rd) check("read data", host_rdata, model_read(int'(host_idx)));
    model_step();
    @(posedge clk);
    @(negedge clk);
    check("outputs", {28'd0, xfer_ack, xfer_rej, abort_req, 1'b0},
          {28'd0, e_ack, e_rej, e_abort, 1'b0});
    check("grant", xfer_grant, e_grant);
    check("chunk addr", xfer_addr, e_addr);
    host_wr = 0; host_rd = 0; core_done = 0; xfer_req = 0;
  endtask

  task automatic wr(input int idx, input bit [31:0] d);
    host_wr = 1; host_idx = 3'(idx); host_wdata = d; tick();
  endtask
  task automatic rd(input int idx);
    host_rd = 1; host_idx = 3'(idx); tick();
  endtask
  task automatic chunk(input bit dir, input bit [31:0] len);
    xfer_req = 1; xfer_to_mem = dir; xfer_len = len; tick();
  endtask
  task automatic cdone();
    core_done = 1; tick();
  endtask

  initial begin
    #1_000_000;
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    rst_n = 0; host_wr = 0; host_rd = 0; host_idx = 0; host_wdata = 0; clr_by_write = 0;
    core_irq = 0; core_done = 0; xfer_req = 0; xfer_to_mem = 0; xfer_len = 0;
    foreach (m[i]) m[i] = 0;
    m[4] = 32'hFFFF_FFFF; m[7] = 32'hFFFF_FFFD;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    check("ack after reset", {31'd0, xfer_ack}, 0);
    for (int i = 0; i < 8; i++) rd(i);
    check("reset waddr", m[4], 32'hFFFF_FFFF);

    tag = "R2";
    wr(1, 32'h0000_0100); wr(2, 32'h1000_0000); wr(6, 32'hABCD_0000);
    wr(3, 32'h1234_5678); wr(4, 32'h0BAD_F00D); wr(7, 32'h5555_AAAA);
    for (int i = 0; i < 8; i++) rd(i);

    tag = "R3";
    wr(0, 32'h83);
    rd(3); rd(4); rd(7); rd(5);

    tag = "R8";
    chunk(0, 32'h10);
    rd(3); rd(4);

    tag = "R9";
    chunk(1, 32'h40); chunk(1, 32'h80);
    rd(3); rd(4);
    tag = "R10";
    chunk(1, 32'h100);
    rd(3);

    tag = "R7";
    wr(5, 32'hFF);
    rd(5); rd(5);

    tag = "R5";
    core_irq = 1; rd(5); core_irq = 0; rd(5);

    tag = "R11";
    clr_by_write = 1;
    wr(1, 32'h20); wr(0, 32'h83);
    cdone();
    rd(3); rd(5);
    tag = "R6";
    rd(5); wr(5, 32'h06); rd(5); wr(5, 32'h08); rd(5);

    tag = "R4";
    wr(0, 32'h02); tick();
    wr(0, 32'h01); rd(0); wr(0, 32'h00); rd(0);

    tag = "R3";
    wr(0, 32'h83); cdone(); rd(5); wr(0, 32'h83); rd(5); rd(3);

    tag = "R9";
    begin
      bit [31:0] s = 32'h1357_9BDF;
      wr(1, 32'h300); wr(2, 32'h8000_0004); wr(0, 32'h03);
      for (int k = 0; k < 24; k++) begin
        s = s * 32'd1103515245 + 32'd12345;
        chunk(s[20] & s[3], {24'd0, s[15:8]});
        if (k % 6 == 5) rd(3);
      end
      clr_by_write = 0; rd(5); rd(5); rd(4);
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule